// File: doc/BRIEF.md
# Edge-Triggered Line Interrupt Controller

The block monitors a bank of asynchronous digital input lines and turns selected transitions on them into one level-sensitive interrupt request. Each line may be armed separately for low-to-high changes, for high-to-low changes, or for both. Every detected and armed transition leaves a sticky pending flag. Software reads the flags and acknowledges them by writing ones. A master enable bit gates whether any pending flag may drive the request pin.

Software reaches the block through a plain synchronous register port. It presents an address, a write strobe and write data, and it gets combinational read data for the current address. The request pin is registered. The input lines are resynchronised inside the block before any transition is judged, so they may change at any time.

Top module: `line_edge_irq`

## Requirements
- R1: After reset, the arm register, the pending register and the control register all read 0, and irq_o is 0.
- R2: The arm register sits at byte address 0x114. It is 32 bits wide and read/write, and it reads back exactly what was last written to it.
- R3: Arm bit n (n = 0..15) enables low-to-high detection on line n. Such a transition sets pending bit n, and pending is read at address 0x118.
- R4: Arm bit 16+n enables high-to-low detection on line n. Such a transition sets pending bit 16+n.
- R5: A transition whose arm bit is 0 sets no pending bit.
- R6: Suppose a line change is first sampled by rising clock edge j. Its pending bit reads set after edge j+2 and does not read set after edge j+1.
- R7: A write to 0x118 clears each pending bit whose write-data bit is 1. Bits written 0 keep their value.
- R8: If a transition sets a pending bit at the same clock edge as a write that clears it, the bit stays set.
- R9: Clearing an arm bit leaves an already-set pending bit set, and it stops later transitions of that kind from being recorded.
- R10: At each clock edge, irq_o takes the value (master enable AND the OR of all pending bits) as they were before that edge.
- R11: The control register sits at 0x100. Bit 0 is the master enable, and all other bits read 0.
- R12: Any other address reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lines_i | input | 16 | Monitored input lines, asynchronous |
| irq_o | output | 1 | Registered interrupt request |

## Verification
An armed transition can reach its pending bit at the same clock edge as a software write that acknowledges that bit. The bench provokes this by raising a line and then timing the acknowledge write so that its strobe is sampled two edges after the line was first sampled. It then expects the bit to remain set. A behavioural reference model tracks line history in a queue and is compared against read data and irq_o after every edge, so any ordering mistake between set and clear shows up in that cycle.

// File: rtl/line_edge_irq_pkg.sv
package line_edge_irq_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_ARM,
    SEL_PEND
  } reg_sel_e;

  localparam logic [11:0] DEF_OFF_CTRL = 12'h100;
  localparam logic [11:0] DEF_OFF_ARM  = 12'h114;
  localparam logic [11:0] DEF_OFF_PEND = 12'h118;

endpackage

// File: rtl/line_edge_detect.sv
module line_edge_detect #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev_q <= chain[LAST];
    end
  end

  assign rise_o = chain[LAST] & ~prev_q;
  assign fall_o = ~chain[LAST] & prev_q;

endmodule

// File: rtl/line_pend_bank.sv
module line_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R7: with no acknowledge, no pending bit is lost
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R8: a set in the same cycle as its clear survives
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i & clr_i) != '0) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

  // R5: a bit only appears when a set request was present
  p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/line_irq_gate.sv
module line_irq_gate #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mie_i,
  input  logic [W-1:0] pend_i,
  output logic         irq_o
);

  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= mie_i & (|pend_i);
  end

  assign irq_o = irq_q;

  // R10: master enable off blocks the request next cycle
  p_mie_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mie_i |=> !irq_o);

  // R10: nothing pending means no request next cycle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> !irq_o);

endmodule

// File: rtl/line_edge_irq.sv
module line_edge_irq
  import line_edge_irq_pkg::*;
#(
  parameter int unsigned NLINES      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(DEF_OFF_CTRL),
  parameter logic [ADDR_W-1:0] OFF_ARM  = ADDR_W'(DEF_OFF_ARM),
  parameter logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(DEF_OFF_PEND)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic [2*NLINES-1:0]   bus_wdata,
  output logic [2*NLINES-1:0]   bus_rdata,
  input  logic [NLINES-1:0]     lines_i,
  output logic                  irq_o
);

  localparam int unsigned REG_W = 2 * NLINES;

  reg_sel_e          sel;
  logic [REG_W-1:0]  arm_q;
  logic              mie_q;
  logic [NLINES-1:0] rise, fall;
  logic [REG_W-1:0]  set_vec, clr_vec, pend;

  always_comb begin
    if      (bus_addr == OFF_CTRL) sel = SEL_CTRL;
    else if (bus_addr == OFF_ARM)  sel = SEL_ARM;
    else if (bus_addr == OFF_PEND) sel = SEL_PEND;
    else                           sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
      mie_q <= 1'b0;
    end else if (bus_we) begin
      if (sel == SEL_ARM)  arm_q <= bus_wdata;
      if (sel == SEL_CTRL) mie_q <= bus_wdata[0];
    end
  end

  line_edge_detect #(.W(NLINES), .STAGES(SYNC_STAGES)) u_detect (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (lines_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar n = 0; n < NLINES; n++) begin : g_arm
    assign set_vec[n]        = rise[n] & arm_q[n];
    assign set_vec[NLINES+n] = fall[n] & arm_q[NLINES+n];
  end

  assign clr_vec = (bus_we && sel == SEL_PEND) ? bus_wdata : '0;

  line_pend_bank #(.W(REG_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  line_irq_gate #(.W(REG_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .mie_i  (mie_q),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = {{(REG_W-1){1'b0}}, mie_q};
      SEL_ARM:  bus_rdata = arm_q;
      SEL_PEND: bus_rdata = pend;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a write to the arm register is held afterwards
  p_arm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_ARM) |=> (arm_q == $past(bus_wdata)));

  // R12: writes elsewhere leave the arm register untouched
  p_arm_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == OFF_ARM) |=> $stable(arm_q));

endmodule

// File: tb/line_edge_irq_test.sv
module line_edge_irq_test;

  localparam logic [11:0] A_CTRL = 12'h100;
  localparam logic [11:0] A_ARM  = 12'h114;
  localparam logic [11:0] A_PEND = 12'h118;
  localparam logic [11:0] A_NONE = 12'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] lines_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  line_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lines_i(lines_i), .irq_o(irq_o)
  );

  // reference model
  logic [15:0] hist[$];
  logic [31:0] m_arm = '0, m_pend = '0;
  logic        m_mie = 1'b0, m_irq = 1'b0;

  function automatic logic [31:0] m_read(logic [11:0] a);
    if (a == A_CTRL) return {31'b0, m_mie};
    if (a == A_ARM)  return m_arm;
    if (a == A_PEND) return m_pend;
    return 32'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{16'h0, 16'h0, 16'h0};
      m_arm = '0; m_pend = '0; m_mie = 1'b0; m_irq = 1'b0;
    end else begin
      logic [15:0] cur, old, r, f;
      logic [31:0] clr, nxt;
      cur = hist[hist.size()-2];
      old = hist[hist.size()-3];
      r = cur & ~old;
      f = ~cur & old;
      clr = (bus_we && bus_addr == A_PEND) ? bus_wdata : 32'h0;
      nxt = (m_pend & ~clr) | {f & m_arm[31:16], r & m_arm[15:0]};
      m_irq = m_mie & (|m_pend);
      if (bus_we && bus_addr == A_ARM)  m_arm = bus_wdata;
      if (bus_we && bus_addr == A_CTRL) m_mie = bus_wdata[0];
      m_pend = nxt;
      hist.push_back(lines_i);
      if (hist.size() > 4) void'(hist.pop_front());
      #2;
      chk(irq_o == m_irq, "R10 model irq", {31'b0, irq_o}, {31'b0, m_irq});
      if (bus_addr == A_ARM)       chk(bus_rdata == m_read(bus_addr), "R2 model arm", bus_rdata, m_read(bus_addr));
      else if (bus_addr == A_PEND) chk(bus_rdata == m_read(bus_addr), "R3 model pend", bus_rdata, m_read(bus_addr));
      else if (bus_addr == A_CTRL) chk(bus_rdata == m_read(bus_addr), "R11 model ctrl", bus_rdata, m_read(bus_addr));
      else                         chk(bus_rdata == 32'h0, "R12 model unmapped", bus_rdata, 32'h0);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_lines(logic [15:0] v);
    @(negedge clk);
    lines_i = v;
  endtask

  initial begin
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset values
    rd_chk(A_ARM, 32'h0, "R1 arm reset");
    rd_chk(A_PEND, 32'h0, "R1 pend reset");
    rd_chk(A_CTRL, 32'h0, "R1 ctrl reset");
    chk(irq_o === 1'b0, "R1 irq reset", {31'b0, irq_o}, 32'h0);

    // R2 arm rise lines 0,2 and fall lines 0,1
    wr(A_ARM, 32'h0003_0005);
    rd_chk(A_ARM, 32'h0003_0005, "R2 arm readback");

    // R3 R5 R6 raise lines 0,1,2; line 1 rise not armed
    rd_chk(A_PEND, 32'h0, "R6 pend before");
    set_lines(16'h0007);
    @(posedge clk);
    @(posedge clk); #1;
    chk(bus_rdata === 32'h0, "R6 not yet after j+1", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk(bus_rdata === 32'h0000_0005, "R3 R5 R6 rise pending", bus_rdata, 32'h0000_0005);
    idle(2);
    chk(irq_o === 1'b0, "R10 irq held by master off", {31'b0, irq_o}, 32'h0);

    // R11 master enable, upper bits read 0
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk(A_CTRL, 32'h1, "R11 ctrl readback");
    idle(1);
    chk(irq_o === 1'b1, "R10 irq asserted", {31'b0, irq_o}, 32'h1);

    // R4 drop lines 0,1
    set_lines(16'h0004);
    idle(4);
    rd_chk(A_PEND, 32'h0003_0005, "R4 fall pending");

    // R7 acknowledge
    wr(A_PEND, 32'h0000_0001);
    rd_chk(A_PEND, 32'h0003_0004, "R7 w1c one bit");
    wr(A_PEND, 32'h0000_0000);
    rd_chk(A_PEND, 32'h0003_0004, "R7 zero write keeps");

    // R9 disarm keeps pending, blocks new
    wr(A_ARM, 32'h0);
    rd_chk(A_PEND, 32'h0003_0004, "R9 pending kept");
    set_lines(16'h0000);
    idle(4);
    set_lines(16'h0004);
    idle(4);
    rd_chk(A_PEND, 32'h0003_0004, "R9 no new events");

    // clear all, irq falls
    wr(A_PEND, 32'hFFFF_FFFF);
    rd_chk(A_PEND, 32'h0, "R7 clear all");
    idle(1);
    chk(irq_o === 1'b0, "R10 irq released", {31'b0, irq_o}, 32'h0);

    // R8 set and clear at the same edge
    wr(A_ARM, 32'h0000_0008);
    set_lines(16'h000C);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = A_PEND; bus_we = 1'b1; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    #1;
    chk(bus_rdata === 32'h0000_0008, "R8 set wins", bus_rdata, 32'h0000_0008);
    wr(A_PEND, 32'h0000_0008);
    rd_chk(A_PEND, 32'h0, "R8 later clear");

    // R12 unmapped address
    rd_chk(A_NONE, 32'h0, "R12 unmapped read");
    wr(A_NONE, 32'hFFFF_FFFF);
    rd_chk(A_ARM, 32'h0000_0008, "R12 arm unchanged");
    rd_chk(A_CTRL, 32'h1, "R12 ctrl unchanged");
    rd_chk(A_PEND, 32'h0, "R12 pend unchanged");

    idle(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule